// File: doc/BRIEF.md
# PWM Buffered Register Synchronizer

This block sits beside a PWM counter and keeps two copies of the period (modulo), the per-channel compare values and the channel output mask: a buffered copy, which the register write port loads, and an active copy, which drives the waveform logic. Writes land only in the buffered copy. The active copy takes the buffered values only when a synchronization event occurs. The same event can also send a one-cycle reinitialization pulse to the counter.

An event comes from a request bit in the control word, which software sets and the block clears, or from a rising edge on one of the hardware trigger inputs. The control word holds a restriction bit that sorts the updates into two groups. With the restriction on, a software request moves only the period and compare values. A hardware edge moves only the output mask and the counter reinit. A second mode bit switches the restriction off. A separate command bit loads the channel outputs once from an init-value register.

Top module: `pwm_sync_regs`

## Requirements
- R1: A write to the modulo (address 0), mask (address 1) or compare (address 4+i) buffer is readable at once on the read port. It does not change act_mod, act_mask or act_cmp until a permitted synchronization event occurs.
- R2: Writing 1 to control bit 0 (address 2) requests a software event. The event is applied on the second rising edge after the edge on which the write is presented. The bit then reads back as 0.
- R3: A rising edge on any hw_trig bit, presented before a clock edge, applies a hardware event on the second rising edge after it. An input held high produces no further event.
- R4: With control bit 1 (restriction) at 0, either event class copies modulo, compare values and mask into the active registers.
- R5: With control bit 1 at 1 and control bit 2 at 0, a software event copies only modulo and compare values. A hardware event copies only the mask and is the only class that can raise the counter reinit.
- R6: With control bit 2 (alternate mode) at 1, the restriction bit has no effect and the block behaves as in R4.
- R7: cnt_reinit is high for exactly one cycle, in the cycle after the mask group is applied, and only when control bit 4 (reinit enable) is 1.
- R8: Writing a control word with bit 3 set loads ch_out from the init-value register (address 3) at that write edge. A control write with bit 3 at 0 leaves ch_out unchanged. Bit 3 always reads back as 0.
- R9: A software request and a hardware edge that are applied in the same cycle produce the union of both permitted groups.
- R10: After reset all active values, ch_out, cnt_reinit and the control word are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | CW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | CW | Combinational read data (buffers, control, init value) |
| hw_trig | input | NTRIG | Hardware trigger inputs, rising-edge sensitive |
| act_mod | output | CW | Active period value |
| act_cmp | output | NCH*CW | Active compare values, channel i at bits i*CW +: CW |
| act_mask | output | NCH | Active output mask |
| ch_out | output | NCH | Channel output state set by the init command |
| cnt_reinit | output | 1 | One-cycle counter reinitialization pulse |

## Verification
The assertions assume that hw_trig is already synchronous to clk and holds steady across each edge. They also assume that no buffer write falls in the same cycle as the event that would copy that buffer. The stimulus changes all inputs only on the falling edge. It keeps each trigger low for at least one cycle between pulses, and it finishes the buffer writes of a trial before raising the trigger or the software request. Random trials pick the buffer contents, the three mode bits and the trigger mix. Directed cases cover reset, the init command, a held trigger and simultaneous software and hardware events.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  // control word bit positions
  localparam int CTL_SWREQ   = 0;
  localparam int CTL_LIMIT   = 1;
  localparam int CTL_ALT     = 2;
  localparam int CTL_INIT    = 3;
  localparam int CTL_REINIT  = 4;
  localparam int CTL_W       = 5;

  // register addresses
  localparam int ADR_MOD   = 0;
  localparam int ADR_MASK  = 1;
  localparam int ADR_CTL   = 2;
  localparam int ADR_INIT  = 3;
  localparam int ADR_CMP0  = 4;

  typedef struct packed {
    logic per_cmp;   // period and compare group
    logic msk_cnt;   // mask and counter reinit group
  } grant_t;

  // which update groups an event of each class may touch
  function automatic grant_t sync_grant(input logic sw_ev, input logic hw_ev,
                                        input logic limit, input logic alt);
    logic split;
    grant_t g;
    split     = limit & ~alt;
    g.per_cmp = sw_ev | (hw_ev & ~split);
    g.msk_cnt = hw_ev | (sw_ev & ~split);
    return g;
  endfunction
endpackage

// File: rtl/pwm_sync_trig.sv
module pwm_sync_trig #(
  parameter int NTRIG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] trig_i,
  output logic [NTRIG-1:0] pulse_o
);
  logic [NTRIG-1:0] prev_q;

  for (genvar t = 0; t < NTRIG; t++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q[t]  <= 1'b0;
        pulse_o[t] <= 1'b0;
      end else begin
        prev_q[t]  <= trig_i[t];
        pulse_o[t] <= trig_i[t] & ~prev_q[t];
      end
    end

    // R3: an edge yields exactly one pulse cycle
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o[t] |=> !pulse_o[t]);
  end
endmodule

// File: rtl/pwm_sync_shadow.sv
module pwm_sync_shadow #(
  parameter int NCH = 4,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mod,
  input  logic              wr_mask,
  input  logic [NCH-1:0]    wr_cmp,
  input  logic [CW-1:0]     wdata,
  input  logic              upd_pc,
  input  logic              upd_mk,
  output logic [CW-1:0]     buf_mod,
  output logic [NCH-1:0]    buf_mask,
  output logic [NCH*CW-1:0] buf_cmp,
  output logic [CW-1:0]     act_mod,
  output logic [NCH-1:0]    act_mask,
  output logic [NCH*CW-1:0] act_cmp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_mod  <= '0;
      buf_mask <= '0;
      act_mod  <= '0;
      act_mask <= '0;
    end else begin
      if (wr_mod)  buf_mod  <= wdata;
      if (wr_mask) buf_mask <= wdata[NCH-1:0];
      if (upd_pc)  act_mod  <= buf_mod;
      if (upd_mk)  act_mask <= buf_mask;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        buf_cmp[c*CW +: CW] <= '0;
        act_cmp[c*CW +: CW] <= '0;
      end else begin
        if (wr_cmp[c]) buf_cmp[c*CW +: CW] <= wdata;
        if (upd_pc)    act_cmp[c*CW +: CW] <= buf_cmp[c*CW +: CW];
      end
    end

    // R1: compare active value moves only with a granted event
    p_cmp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_pc |=> $stable(act_cmp[c*CW +: CW]));
  end

  // R1: period and mask hold without a granted event
  p_mod_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_pc |=> $stable(act_mod));
  p_mask_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_mk |=> $stable(act_mask));
endmodule

// File: rtl/pwm_sync_ctrl.sv
module pwm_sync_ctrl
  import pwm_sync_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic             wr_init,
  input  logic [CTL_W-1:0] ctl_data,
  input  logic [NCH-1:0]   init_data,
  input  logic             hw_ev,
  output logic             swreq_q,
  output logic             limit_q,
  output logic             alt_q,
  output logic             reinit_en_q,
  output logic [NCH-1:0]   init_q,
  output logic [NCH-1:0]   ch_out,
  output logic             upd_pc,
  output logic             upd_mk,
  output logic             cnt_reinit
);
  grant_t grant;
  logic   sw_set;
  logic   init_cmd;

  assign sw_set   = wr_ctl & ctl_data[CTL_SWREQ];
  assign init_cmd = wr_ctl & ctl_data[CTL_INIT];
  assign grant    = sync_grant(swreq_q, hw_ev, limit_q, alt_q);
  assign upd_pc   = grant.per_cmp;
  assign upd_mk   = grant.msk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swreq_q     <= 1'b0;
      limit_q     <= 1'b0;
      alt_q       <= 1'b0;
      reinit_en_q <= 1'b0;
      init_q      <= '0;
      ch_out      <= '0;
      cnt_reinit  <= 1'b0;
    end else begin
      // a new request wins over the clear of an applied one
      if (sw_set)       swreq_q <= 1'b1;
      else if (swreq_q) swreq_q <= 1'b0;
      if (wr_ctl) begin
        limit_q     <= ctl_data[CTL_LIMIT];
        alt_q       <= ctl_data[CTL_ALT];
        reinit_en_q <= ctl_data[CTL_REINIT];
      end
      if (wr_init)  init_q <= init_data;
      if (init_cmd) ch_out <= init_q;
      cnt_reinit <= upd_mk & reinit_en_q;
    end
  end

  // R2: the request clears itself after one applied cycle
  p_swreq_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (swreq_q && !sw_set) |=> !swreq_q);
  // R5: a restricted software event never touches the mask group
  p_limit_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_q && !alt_q && !hw_ev) |-> !upd_mk);
  // R7: reinit follows only a granted mask group with enable set
  p_reinit_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_reinit |-> $past(upd_mk && reinit_en_q));
  // R8: init command copies the init register
  p_init_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_cmd |=> ch_out == $past(init_q));
  p_init_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !init_cmd |=> $stable(ch_out));
endmodule

// File: rtl/pwm_sync_regs.sv
module pwm_sync_regs
  import pwm_sync_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CW    = 16,
  parameter int NTRIG = 3,
  parameter int AW    = 4   // needs ADR_CMP0 + NCH <= 2**AW, NCH and CTL_W <= CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [CW-1:0]     rd_data,
  input  logic [NTRIG-1:0]  hw_trig,
  output logic [CW-1:0]     act_mod,
  output logic [NCH*CW-1:0] act_cmp,
  output logic [NCH-1:0]    act_mask,
  output logic [NCH-1:0]    ch_out,
  output logic              cnt_reinit
);
  logic [NTRIG-1:0]  hw_pulse;
  logic              hw_ev;
  logic              wr_mod, wr_mask, wr_ctl, wr_init;
  logic [NCH-1:0]    wr_cmp;
  logic              upd_pc, upd_mk;
  logic              swreq_q, limit_q, alt_q, reinit_en_q;
  logic [NCH-1:0]    init_q;
  logic [CW-1:0]     buf_mod;
  logic [NCH-1:0]    buf_mask;
  logic [NCH*CW-1:0] buf_cmp;
  logic [CTL_W-1:0]  ctl_view;

  assign wr_mod  = wr_en && (wr_addr == AW'(ADR_MOD));
  assign wr_mask = wr_en && (wr_addr == AW'(ADR_MASK));
  assign wr_ctl  = wr_en && (wr_addr == AW'(ADR_CTL));
  assign wr_init = wr_en && (wr_addr == AW'(ADR_INIT));
  for (genvar c = 0; c < NCH; c++) begin : g_wsel
    assign wr_cmp[c] = wr_en && (wr_addr == AW'(ADR_CMP0 + c));
  end

  assign hw_ev = |hw_pulse;

  pwm_sync_trig #(.NTRIG(NTRIG)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_i(hw_trig), .pulse_o(hw_pulse)
  );

  pwm_sync_ctrl #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_init(wr_init),
    .ctl_data(wr_data[CTL_W-1:0]), .init_data(wr_data[NCH-1:0]),
    .hw_ev(hw_ev), .swreq_q(swreq_q), .limit_q(limit_q), .alt_q(alt_q),
    .reinit_en_q(reinit_en_q), .init_q(init_q), .ch_out(ch_out),
    .upd_pc(upd_pc), .upd_mk(upd_mk), .cnt_reinit(cnt_reinit)
  );

  pwm_sync_shadow #(.NCH(NCH), .CW(CW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_mod(wr_mod), .wr_mask(wr_mask),
    .wr_cmp(wr_cmp), .wdata(wr_data), .upd_pc(upd_pc), .upd_mk(upd_mk),
    .buf_mod(buf_mod), .buf_mask(buf_mask), .buf_cmp(buf_cmp),
    .act_mod(act_mod), .act_mask(act_mask), .act_cmp(act_cmp)
  );

  always_comb begin
    ctl_view             = '0;
    ctl_view[CTL_SWREQ]  = swreq_q;
    ctl_view[CTL_LIMIT]  = limit_q;
    ctl_view[CTL_ALT]    = alt_q;
    ctl_view[CTL_REINIT] = reinit_en_q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(ADR_MOD))  rd_data = buf_mod;
    if (rd_addr == AW'(ADR_MASK)) rd_data = CW'(buf_mask);
    if (rd_addr == AW'(ADR_CTL))  rd_data = CW'(ctl_view);
    if (rd_addr == AW'(ADR_INIT)) rd_data = CW'(init_q);
    for (int c = 0; c < NCH; c++)
      if (rd_addr == AW'(ADR_CMP0 + c)) rd_data = buf_cmp[c*CW +: CW];
  end

  // R3: any hardware pulse loads the mask in every mode
  p_hw_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_ev |=> act_mask == $past(buf_mask));
  // R2: a pending software request loads the period in every mode
  p_sw_mod_r2: assert property (@(posedge clk) disable iff (!rst_n)
    swreq_q |=> act_mod == $past(buf_mod));
endmodule

// File: tb/pwm_sync_regs_test.sv
module pwm_sync_regs_test;
  localparam int NCH = 4, CW = 16, NTRIG = 3, AW = 4;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0, rd_addr = '0;
  logic [CW-1:0]     wr_data = '0;
  logic [CW-1:0]     rd_data;
  logic [NTRIG-1:0]  hw_trig = '0;
  logic [CW-1:0]     act_mod;
  logic [NCH*CW-1:0] act_cmp;
  logic [NCH-1:0]    act_mask, ch_out;
  logic              cnt_reinit;

  int vectors = 0, miscompares = 0;
  logic [CW-1:0]  b_mod = '0, a_mod = '0;
  logic [NCH-1:0] b_mask = '0, a_mask = '0, m_init = '0, m_ch = '0;
  logic [CW-1:0]  b_cmp [NCH];
  logic [CW-1:0]  a_cmp [NCH];

  pwm_sync_regs #(.NCH(NCH), .CW(CW), .NTRIG(NTRIG), .AW(AW)) uut (.*);

  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [NCH*CW-1:0] pack(input logic [CW-1:0] v [NCH]);
    logic [NCH*CW-1:0] r;
    for (int c = 0; c < NCH; c++) r[c*CW +: CW] = v[c];
    return r;
  endfunction

  task automatic wr(input int adr, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(adr); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int adr, output logic [CW-1:0] d);
    rd_addr = AW'(adr);
    #1 d = rd_data;
  endtask

  task automatic wbuf(input int adr, input logic [CW-1:0] d);
    logic [CW-1:0] r;
    wr(adr, d);
    if (adr == 0) b_mod = d;
    else if (adr == 1) b_mask = d[NCH-1:0];
    else b_cmp[adr-4] = d;
    rd(adr, r);
    chk("R1 readback", 64'(r), adr == 1 ? 64'(d[NCH-1:0]) : 64'(d));
  endtask

  // bench restatement of the group permission rule
  function automatic logic [1:0] allow(input logic sw, input logic hw,
                                       input logic lim, input logic alt);
    logic split, pc, mk;
    split = lim && !alt;
    pc = sw ? 1'b1 : (hw && !split);
    mk = hw ? 1'b1 : (sw && !split);
    return {pc, mk};
  endfunction

  task automatic fire(input logic sw, input logic [NTRIG-1:0] hw, input logic lim,
                      input logic alt, input logic ren);
    logic [1:0] g;
    string tag;
    logic [CW-1:0] r;
    g = allow(sw, hw != 0, lim, alt);
    if (sw && hw != 0)      tag = "R9";
    else if (lim && !alt)   tag = "R5";
    else if (lim && alt)    tag = "R6";
    else if (sw || hw != 0) tag = "R4";
    else                    tag = "R1";
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(2); wr_data = CW'({ren, 1'b0, alt, lim, sw});
    hw_trig = hw;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R1 early mod", 64'(act_mod), 64'(a_mod));
    chk("R7 early reinit", 64'(cnt_reinit), 64'd0);
    @(negedge clk);
    if (g[1]) begin a_mod = b_mod; for (int c = 0; c < NCH; c++) a_cmp[c] = b_cmp[c]; end
    if (g[0]) a_mask = b_mask;
    chk({tag, " mod"}, 64'(act_mod), 64'(a_mod));
    chk({tag, " cmp"}, act_cmp, pack(a_cmp));
    chk({tag, " mask"}, 64'(act_mask), 64'(a_mask));
    chk("R7 reinit", 64'(cnt_reinit), 64'(g[0] && ren));
    rd(2, r);
    chk("R2 request cleared", 64'(r[0]), 64'd0);
    @(negedge clk);
    chk("R3 held trigger no reinit", 64'(cnt_reinit), 64'd0);
    chk("R3 held trigger no mask move", 64'(act_mask), 64'(a_mask));
    hw_trig = '0;
  endtask

  initial begin
    logic [CW-1:0] r;
    for (int c = 0; c < NCH; c++) begin b_cmp[c] = '0; a_cmp[c] = '0; end
    void'($urandom(32'h5eed));
    #35 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 mod", 64'(act_mod), 64'd0);
    chk("R10 cmp", act_cmp, 64'd0);
    chk("R10 mask", 64'(act_mask), 64'd0);
    chk("R10 ch_out", 64'(ch_out), 64'd0);
    chk("R10 reinit", 64'(cnt_reinit), 64'd0);
    rd(2, r);
    chk("R10 ctl", 64'(r), 64'd0);

    // directed: buffers do not leak, then each class in each mode
    wbuf(0, 16'h1234); wbuf(1, 16'h000a); wbuf(4, 16'h0f0f); wbuf(7, 16'hbeef);
    fire(1'b0, 3'b000, 1'b0, 1'b0, 1'b1);
    fire(1'b1, 3'b000, 1'b1, 1'b0, 1'b1);
    wbuf(1, 16'h0005); wbuf(0, 16'h4321);
    fire(1'b0, 3'b010, 1'b1, 1'b0, 1'b1);
    wbuf(0, 16'h7777); wbuf(1, 16'h0003);
    fire(1'b1, 3'b000, 1'b0, 1'b0, 1'b1);
    wbuf(0, 16'h1111); wbuf(1, 16'h000c);
    fire(1'b0, 3'b100, 1'b1, 1'b1, 1'b0);
    wbuf(0, 16'h2222); wbuf(1, 16'h0009);
    fire(1'b1, 3'b001, 1'b1, 1'b0, 1'b1);

    // R8: init command
    wr(3, 16'h0006); m_init = 4'h6;
    wr(2, 16'h0008); m_ch = m_init;
    chk("R8 load", 64'(ch_out), 64'(m_ch));
    rd(2, r);
    chk("R8 cmd reads 0", 64'(r[3]), 64'd0);
    wr(3, 16'h0009);
    wr(2, 16'h0000);
    chk("R8 no load on 0", 64'(ch_out), 64'(m_ch));
    wr(2, 16'h0008); m_ch = 4'h9;
    chk("R8 reload", 64'(ch_out), 64'(m_ch));

    // random trials
    for (int t = 0; t < 200; t++) begin
      int nw;
      nw = $urandom_range(0, 3);
      for (int k = 0; k < nw; k++) begin
        int a;
        a = $urandom_range(0, 5);
        a = (a >= 2) ? a + 2 : a;
        wbuf(a, CW'($urandom));
      end
      fire(1'($urandom), NTRIG'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      chk("R8 ch_out untouched", 64'(ch_out), 64'(m_ch));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule